// File: doc/BRIEF.md
# ADC Accumulate-and-Repeat Sequencer

This block is the digital control wrapped around a successive-approximation converter. Each time it is triggered it runs a programmed set of 1, 4, 8 or 16 conversions and adds every 10-bit result into a single 16-bit accumulator. It raises its end-of-set and window interrupt requests only once, after the final conversion of the set. Summing several conversions this way gives a cheap oversampled reading without software touching each sample.

The timing of the converter comes from a SAR clock enable, made by dividing the block clock by a programmable value plus one. Every conversion takes twelve SAR clocks: two to track and ten to resolve bits. In triggered mode, each conversion of a set waits for its own start pulse. In burst mode, one start pulse runs the whole set back to back. The analog side is a behavioural model that captures the analog input at the end of tracking and returns it when the conversion completes.

An 8-bit configuration register holds the divide field in bits 7..3, the set-length code in bits 2..1 and a reserved bit 0. Left justification is only honoured for single-conversion sets. For longer sets the result is forced right justified and an error output is raised.

Top module: `adc_accum_seq`

## Requirements
- R1: After reset the configuration register reads 0xF8 (divide field 31, set-length code 00). Bit 0 always reads 0, even when it is written 1.
- R2: The SAR clock runs at the block clock divided by (divide field + 1), and each conversion lasts 12 SAR clocks. A single-conversion set therefore finishes between 12·(d+1) and 12·(d+1)+4 block clocks after its start pulse.
- R3: Set-length code 00, 01, 10, 11 (bits 2..1) selects 1, 4, 8 or 16 conversions. The right-justified 10-bit results of the set are summed into the 16-bit `result`.
- R4: The accumulator is cleared when a new set begins, so a set's result never includes values from an earlier set.
- R5: With `burst_en` low, each conversion needs its own start pulse. Between conversions of an unfinished set, `busy` stays high and `eoc_irq` stays low.
- R6: With `burst_en` high at the start pulse, the whole set runs from that one pulse.
- R7: A start pulse that arrives while a conversion or a burst set is running is ignored. It adds no conversion and does not restart the set.
- R8: `busy` rises on the cycle after an accepted start that opens a set. It falls on the same clock edge at which `eoc_irq` rises.
- R9: `eoc_irq` and `win_irq` stay set until an `irq_clr` pulse, which clears both on the next edge.
- R10: At the end of a set, `win_irq` is set if the final accumulated result is greater than or equal to `win_limit`. Otherwise it stays low.
- R11: For a single-conversion set with `left_just_req` high, `result` is the sample shifted left by 6. For longer sets the result stays right justified and `just_err` is high while `left_just_req` is high and the code is not 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; also the source of the SAR clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Write strobe for the configuration register |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration register contents |
| burst_en | input | 1 | Burst mode select, sampled at set start |
| left_just_req | input | 1 | Left-justify request |
| start | input | 1 | Conversion start pulse |
| irq_clr | input | 1 | Write-one-to-clear for both interrupt flags |
| ana_in | input | 10 | Analog level seen by the converter model |
| win_limit | input | 16 | Window comparison threshold |
| result | output | 16 | Accumulated result |
| busy | output | 1 | High while a set is in progress |
| eoc_irq | output | 1 | End-of-set interrupt flag |
| win_irq | output | 1 | Window interrupt flag |
| just_err | output | 1 | Left justify requested with a multi-conversion code |

## Verification
A miscounted set length shows up at the first `eoc_irq`. It appears as a result off by a multiple of the sample, or as an interrupt that comes early while a triggered set should still be waiting. An accumulator that is not cleared shows up in the result of the very next set. A wrong divider or phase counter moves the end of a single conversion out of its few-cycle window. A start that is wrongly accepted during a running set shows up as an extra sample in the sum of that same set.

// File: rtl/adc_seq_pkg.sv
// Shared types and helpers for the accumulate-and-repeat sequencer.
// Assumes a 2-bit set-length code with a fixed mapping to set sizes.
package adc_seq_pkg;

    localparam int unsigned LEN_W = 5;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CONV = 2'd1,
        ST_WAIT = 2'd2
    } seq_state_t;

    // Map the set-length code to the number of conversions in a set.
    function automatic logic [LEN_W-1:0] set_size(input logic [1:0] code);
        case (code)
            2'b00:   set_size = 5'd1;
            2'b01:   set_size = 5'd4;
            2'b10:   set_size = 5'd8;
            default: set_size = 5'd16;
        endcase
    endfunction

endpackage

// File: rtl/sar_clk_div.sv
// SAR clock enable generator: one-cycle tick every (div+1) block clocks.
// Assumes clr is pulsed at each conversion launch so phase is repeatable.
module sar_clk_div #(
    parameter int unsigned DIV_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);

    logic [DIV_W-1:0] cnt;

    // Tick fires on the final count of the period unless a restart is pending.
    assign tick = (cnt == div) && !clr;

    // Count the period; restart on clear or after each tick.
    always_ff @(posedge clk) begin
        if (!rst_n || clr || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/sar_conv_stub.sv
// Behavioural converter: TRACK_TICKS of tracking, then BIT_TICKS of bit
// decisions. Captures ana_in at the end of tracking and presents it with
// a one-cycle done pulse. Assumes go is not pulsed while a conversion runs.
module sar_conv_stub #(
    parameter int unsigned SMP_W       = 10,
    parameter int unsigned TRACK_TICKS = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic             tick,
    input  logic [SMP_W-1:0] ana_in,
    output logic             done,
    output logic [SMP_W-1:0] data
);

    localparam int unsigned TOTAL_TICKS = TRACK_TICKS + SMP_W;
    localparam int unsigned PH_W        = $clog2(TOTAL_TICKS + 1);
    localparam logic [PH_W-1:0] TRACK_END = PH_W'(TRACK_TICKS - 1);
    localparam logic [PH_W-1:0] CONV_END  = PH_W'(TOTAL_TICKS - 1);

    logic             running;
    logic [PH_W-1:0]  phase;
    logic [SMP_W-1:0] held;

    // Step the conversion phase on SAR ticks and finish after the last one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running <= 1'b0;
            phase   <= '0;
            held    <= '0;
            done    <= 1'b0;
            data    <= '0;
        end else begin
            done <= 1'b0;
            if (go) begin
                running <= 1'b1;
                phase   <= '0;
            end else if (running && tick) begin
                if (phase == TRACK_END) begin
                    held <= ana_in;
                end
                if (phase == CONV_END) begin
                    running <= 1'b0;
                    done    <= 1'b1;
                    data    <= held;
                    phase   <= '0;
                end else begin
                    phase <= phase + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/adc_seq_ctrl.sv
// Set sequencer: opens a set on start, launches conversions (per start or
// back to back in burst), sums results and raises the interrupt flags
// once the final conversion lands. Assumes conv_done is a one-cycle pulse.
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int unsigned SMP_W = 10,
    parameter int unsigned ACC_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             burst_en,
    input  logic             left_just_req,
    input  logic [1:0]       len_code,
    input  logic             irq_clr,
    input  logic [ACC_W-1:0] win_limit,
    input  logic             conv_done,
    input  logic [SMP_W-1:0] conv_data,
    output logic             conv_go,
    output logic             busy,
    output logic [ACC_W-1:0] acc,
    output logic             eoc_irq,
    output logic             win_irq
);

    localparam int unsigned PAD_W = ACC_W - SMP_W;

    seq_state_t       state;
    logic [LEN_W-1:0] done_cnt;
    logic [LEN_W-1:0] set_len;
    logic             burst_l;
    logic             ljust_l;
    logic [ACC_W-1:0] sample_ext;
    logic [ACC_W-1:0] acc_sum;
    logic             last_conv;
    logic             set_end;

    // Place the sample right justified, or left justified for single sets.
    assign sample_ext = ljust_l ? {conv_data, {PAD_W{1'b0}}}
                                : {{PAD_W{1'b0}}, conv_data};
    assign acc_sum    = acc + sample_ext;
    assign last_conv  = (done_cnt + 1'b1) == set_len;
    assign set_end    = (state == ST_CONV) && conv_done && last_conv;
    assign busy       = (state != ST_IDLE);

    // Walk the set: open, launch, accumulate, close.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            acc      <= '0;
            done_cnt <= '0;
            set_len  <= 5'd1;
            burst_l  <= 1'b0;
            ljust_l  <= 1'b0;
            conv_go  <= 1'b0;
        end else begin
            conv_go <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        acc      <= '0;
                        done_cnt <= '0;
                        set_len  <= set_size(len_code);
                        burst_l  <= burst_en;
                        ljust_l  <= left_just_req && (len_code == 2'b00);
                        conv_go  <= 1'b1;
                        state    <= ST_CONV;
                    end
                end
                ST_CONV: begin
                    if (conv_done) begin
                        acc      <= acc_sum;
                        done_cnt <= done_cnt + 1'b1;
                        if (last_conv) begin
                            state <= ST_IDLE;
                        end else if (burst_l) begin
                            conv_go <= 1'b1;
                        end else begin
                            state <= ST_WAIT;
                        end
                    end
                end
                ST_WAIT: begin
                    if (start) begin
                        conv_go <= 1'b1;
                        state   <= ST_CONV;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Hold the interrupt flags until software clears them; setting wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eoc_irq <= 1'b0;
            win_irq <= 1'b0;
        end else if (set_end) begin
            eoc_irq <= 1'b1;
            win_irq <= (acc_sum >= win_limit);
        end else if (irq_clr) begin
            eoc_irq <= 1'b0;
            win_irq <= 1'b0;
        end
    end

endmodule

// File: rtl/adc_accum_seq.sv
// Top: configuration register, SAR clock divider, converter model and
// set sequencer. Assumes a single clock; the divider restarts per conversion.
module adc_accum_seq #(
    parameter int unsigned DIV_W = 5,
    parameter int unsigned SMP_W = 10,
    parameter int unsigned ACC_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [7:0]       cfg_wdata,
    output logic [7:0]       cfg_rdata,
    input  logic             burst_en,
    input  logic             left_just_req,
    input  logic             start,
    input  logic             irq_clr,
    input  logic [SMP_W-1:0] ana_in,
    input  logic [ACC_W-1:0] win_limit,
    output logic [ACC_W-1:0] result,
    output logic             busy,
    output logic             eoc_irq,
    output logic             win_irq,
    output logic             just_err
);

    localparam int unsigned CFG_W   = DIV_W + 3;
    localparam logic [CFG_W-1:0] CFG_RST = {{DIV_W{1'b1}}, 3'b000};

    logic [CFG_W-1:0] cfg_q;
    logic [DIV_W-1:0] div_val;
    logic [1:0]       len_code;
    logic             conv_go;
    logic             sar_tick;
    logic             conv_done;
    logic [SMP_W-1:0] conv_data;

    // Configuration register; the reserved low bit is kept at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= CFG_RST;
        end else if (cfg_we) begin
            cfg_q <= {cfg_wdata[CFG_W-1:1], 1'b0};
        end
    end

    assign cfg_rdata = 8'(cfg_q);
    assign div_val   = cfg_q[CFG_W-1:3];
    assign len_code  = cfg_q[2:1];
    assign just_err  = left_just_req && (len_code != 2'b00);

    sar_clk_div #(.DIV_W(DIV_W)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (conv_go),
        .div   (div_val),
        .tick  (sar_tick)
    );

    sar_conv_stub #(.SMP_W(SMP_W), .TRACK_TICKS(2)) u_conv (
        .clk    (clk),
        .rst_n  (rst_n),
        .go     (conv_go),
        .tick   (sar_tick),
        .ana_in (ana_in),
        .done   (conv_done),
        .data   (conv_data)
    );

    adc_seq_ctrl #(.SMP_W(SMP_W), .ACC_W(ACC_W)) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .start         (start),
        .burst_en      (burst_en),
        .left_just_req (left_just_req),
        .len_code      (len_code),
        .irq_clr       (irq_clr),
        .win_limit     (win_limit),
        .conv_done     (conv_done),
        .conv_data     (conv_data),
        .conv_go       (conv_go),
        .busy          (busy),
        .acc           (result),
        .eoc_irq       (eoc_irq),
        .win_irq       (win_irq)
    );

endmodule

// File: rtl/adc_seq_checker.sv
// Port-level properties for the sequencer, bound to the top module.
module adc_seq_checker #(
    parameter int unsigned ACC_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [7:0]       cfg_rdata,
    input logic             start,
    input logic             irq_clr,
    input logic [ACC_W-1:0] result,
    input logic             busy,
    input logic             eoc_irq,
    input logic             win_irq
);

    // R1: reserved bit never reads back as one
    a_r1_rsvd_zero: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rdata[0] == 1'b0);

    // R8: busy only drops as the end-of-set flag appears
    a_r8_busy_fall_flag: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> eoc_irq);

    // R8: the flag only rises at the close of a running set
    a_r8_flag_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(eoc_irq) |-> ($past(busy) && !busy));

    // R9: flag holds until a clear pulse
    a_r9_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (eoc_irq && !irq_clr) |=> eoc_irq);

    // R10: window flag only accompanies the end-of-set flag
    a_r10_win_with_eoc: assert property (@(posedge clk) disable iff (!rst_n)
        win_irq |-> eoc_irq);

    // R4: result holds steady while idle with no start
    a_r4_idle_result_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(result));

endmodule

bind adc_accum_seq adc_seq_checker #(.ACC_W(ACC_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_rdata (cfg_rdata),
    .start     (start),
    .irq_clr   (irq_clr),
    .result    (result),
    .busy      (busy),
    .eoc_irq   (eoc_irq),
    .win_irq   (win_irq)
);

// File: tb/sim_adc_accum_seq.sv
// Directed bench: one task per scenario, each checking its own outcome.
module sim_adc_accum_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_wdata = '0;
    logic [7:0]  cfg_rdata;
    logic        burst_en = 1'b0;
    logic        left_just_req = 1'b0;
    logic        start = 1'b0;
    logic        irq_clr = 1'b0;
    logic [9:0]  ana_in = '0;
    logic [15:0] win_limit = 16'hFFFF;
    logic [15:0] result;
    logic        busy;
    logic        eoc_irq;
    logic        win_irq;
    logic        just_err;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    adc_accum_seq u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .burst_en(burst_en), .left_just_req(left_just_req),
        .start(start), .irq_clr(irq_clr), .ana_in(ana_in), .win_limit(win_limit),
        .result(result), .busy(busy), .eoc_irq(eoc_irq), .win_irq(win_irq),
        .just_err(just_err)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic write_cfg(input int dv, input int code);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_wdata = 8'((dv << 3) | (code << 1));
        @(negedge clk);
        cfg_we    = 1'b0;
    endtask

    task automatic pulse_start();
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic clear_irq();
        @(negedge clk);
        irq_clr = 1'b1;
        @(negedge clk);
        irq_clr = 1'b0;
    endtask

    task automatic wait_eoc(output int cyc, input int lim);
        cyc = 0;
        while (!eoc_irq && cyc < lim) begin
            @(negedge clk);
            cyc++;
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic t_reset();
        check(cfg_rdata == 8'hF8, "R1 reset cfg", cfg_rdata, 8'hF8);
        check(!busy && !eoc_irq && !win_irq, "R8 reset flags", {busy, eoc_irq, win_irq}, 0);
        check(result == 0, "R4 reset result", result, 0);
        @(negedge clk);
        cfg_we = 1'b1; cfg_wdata = 8'hFF;
        @(negedge clk);
        cfg_we = 1'b0;
        check(cfg_rdata == 8'hFE, "R1 reserved bit", cfg_rdata, 8'hFE);
    endtask

    task automatic t_timing(input int dv);
        int cyc;
        int lo;
        lo = 12 * (dv + 1);
        write_cfg(dv, 0);
        burst_en = 1'b0;
        ana_in = 10'd321;
        pulse_start();
        check(busy == 1'b1, "R8 busy after start", busy, 1);
        wait_eoc(cyc, 2000);
        check(cyc >= lo && cyc <= lo + 4, "R2 single duration", cyc, lo);
        check(result == 321, "R3 single result", result, 321);
        check(!busy, "R8 busy low at flag", busy, 0);
        clear_irq();
    endtask

    task automatic t_burst(input int code, input int len, input int v);
        int cyc;
        write_cfg(0, code);
        burst_en = 1'b1;
        ana_in = 10'(v);
        pulse_start();
        burst_en = 1'b0;
        wait_eoc(cyc, 4000);
        check(eoc_irq, "R6 burst completes", eoc_irq, 1);
        check(result == 16'(len * v), "R3 burst sum", result, len * v);
        clear_irq();
    endtask

    task automatic t_triggered();
        int cyc;
        int sum;
        int vals[4] = '{10, 200, 1023, 7};
        write_cfg(1, 1);
        burst_en = 1'b0;
        sum = 0;
        for (int k = 0; k < 4; k++) begin
            ana_in = 10'(vals[k]);
            sum += vals[k];
            pulse_start();
            if (k < 3) begin
                idle(45);
                check(busy && !eoc_irq, "R5 waits for next start", {busy, eoc_irq}, 2);
            end
        end
        wait_eoc(cyc, 200);
        check(result == 16'(sum), "R5 triggered sum", result, sum);
        clear_irq();
    endtask

    task automatic t_ignore();
        int cyc;
        write_cfg(0, 1);
        burst_en = 1'b1;
        ana_in = 10'd100;
        pulse_start();
        burst_en = 1'b0;
        idle(6);  pulse_start();
        idle(20); pulse_start();
        wait_eoc(cyc, 2000);
        check(result == 400, "R7 burst restarts ignored", result, 400);
        clear_irq();
        idle(60);
        check(!busy && !eoc_irq, "R7 no extra set", {busy, eoc_irq}, 0);
        write_cfg(1, 0);
        ana_in = 10'd50;
        pulse_start();
        idle(5); pulse_start();
        wait_eoc(cyc, 200);
        check(result == 50, "R7 start during conversion", result, 50);
        idle(40);
        check(!busy, "R7 triggered start dropped", busy, 0);
        clear_irq();
    endtask

    task automatic t_irq_hold();
        int cyc;
        write_cfg(0, 0);
        ana_in = 10'd77;
        pulse_start();
        wait_eoc(cyc, 200);
        idle(10);
        check(eoc_irq, "R9 flag holds", eoc_irq, 1);
        clear_irq();
        check(!eoc_irq && !win_irq, "R9 flag cleared", {eoc_irq, win_irq}, 0);
        ana_in = 10'd5;
        pulse_start();
        wait_eoc(cyc, 200);
        check(result == 5, "R4 accumulator cleared per set", result, 5);
        clear_irq();
    endtask

    task automatic t_window();
        int cyc;
        write_cfg(0, 2);
        burst_en = 1'b1;
        ana_in = 10'd100;
        win_limit = 16'd800;
        pulse_start();
        wait_eoc(cyc, 3000);
        check(win_irq, "R10 at threshold", win_irq, 1);
        clear_irq();
        win_limit = 16'd801;
        pulse_start();
        burst_en = 1'b0;
        wait_eoc(cyc, 3000);
        check(!win_irq && eoc_irq, "R10 below threshold", win_irq, 0);
        clear_irq();
        win_limit = 16'hFFFF;
    endtask

    task automatic t_justify();
        int cyc;
        write_cfg(0, 0);
        left_just_req = 1'b1;
        ana_in = 10'd3;
        check(!just_err, "R11 no error single", just_err, 0);
        pulse_start();
        wait_eoc(cyc, 200);
        check(result == 16'd192, "R11 left justified single", result, 192);
        clear_irq();
        write_cfg(0, 1);
        check(just_err, "R11 error multi", just_err, 1);
        burst_en = 1'b1;
        pulse_start();
        burst_en = 1'b0;
        wait_eoc(cyc, 2000);
        check(result == 16'd12, "R11 forced right justified", result, 12);
        clear_irq();
        left_just_req = 1'b0;
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_timing(0);
        t_timing(3);
        t_burst(0, 1, 513);
        t_burst(1, 4, 1023);
        t_burst(2, 8, 300);
        t_burst(3, 16, 1023);
        t_triggered();
        t_ignore();
        t_irq_hold();
        t_window();
        t_justify();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

endmodule